// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block turns a fast module clock into an enable tick for a serial-peripheral engine. The tick comes at twice the serial-clock rate, so the engine toggles its SCK output once per tick and gets one full SCK period from every two ticks. A single control word selects the division. In linear mode the ratio from module clock to SCK is an even number, 2·(N+1), taken from an 8-bit field. In exponent mode the ratio is a power of two, 2^E, taken from a 4-bit field. The block also reports the ratio in effect.

The control word is latched on a write strobe. Software picks the field values, and the bus decode sits outside this block. Writing the word, or signalling the start of a burst, reloads the half-period counter. The first tick after either event therefore lands exactly one half-period later. While the enable input is low, the tick is held low and the count is frozen.

Top module: `spidiv_sck_gen`

## Requirements
- R1: The control word is latched when `ctl_wr` is high, and it resets to all zeros. The linear divisor N sits in bits 7:0, the exponent E in bits 11:8, and the mode select in bit 12 (1 = linear, 0 = exponent).
- R2: In linear mode the reported ratio is 2·(N+1), which spans 2 (N=0) to 512 (N=255).
- R3: In exponent mode the reported ratio is 2^E for E from 1 to 15. E=0 reports a ratio of 2.
- R4: `ratio` always shows the ratio of the latched word, and that value is even and at least 2.
- R5: While `en` stays high, consecutive ticks are ratio/2 module-clock cycles apart.
- R6: After a control-word write, the first tick comes exactly ratio/2 cycles after the write cycle, and the ratio used is the new one.
- R7: A `burst_start` pulse restarts the count. The next tick comes exactly ratio/2 cycles after it, whatever the count was before.
- R8: When ratio/2 is greater than 1, `tick` is high for exactly one cycle at a time.
- R9: While `en` is low, `tick` stays low and the count holds. After `en` returns high, the interrupted half-period finishes with the cycles it still had left.
- R10: The field that the mode bit does not select has no effect on the ratio or on the tick spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Tick enable; low holds the count |
| ctl_wr | input | 1 | Strobe that latches `ctl_word` |
| ctl_word | input | 13 | Control word: linear N, exponent E, mode bit |
| burst_start | input | 1 | Restarts the half-period count |
| tick | output | 1 | Pulse at twice the SCK rate |
| ratio | output | 16 | Module-clock to SCK ratio in effect |

## Verification
The bench builds the block with its default widths: an 8-bit linear field and a 4-bit exponent field. With these widths both ends of each range can be measured cycle by cycle, including the 256-cycle half-period at linear N=255 and the 16384-cycle half-period at E=15. The smallest settings are also exercised: linear N=0, E=0 and E=1 all give a half-period of one cycle, so the tick stays high continuously.

// File: rtl/spidiv_pkg.sv
package spidiv_pkg;
   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/spidiv_decode.sv
module spidiv_decode
   import spidiv_pkg::*;
#(
   parameter int LIN_W   = 8,
   parameter int EXP_W   = 4,
   localparam int CTL_W   = LIN_W + EXP_W + 1,
   localparam int RATIO_W = imax(LIN_W + 2, 2 ** EXP_W)
) (
   input  logic [CTL_W-1:0]   word,
   output logic [RATIO_W-1:0] ratio,
   output logic [RATIO_W-2:0] half
);
   logic [LIN_W-1:0]   lin_f;
   logic [EXP_W-1:0]   exp_f;
   logic               lin_mode;
   logic [RATIO_W-1:0] lin_ratio;
   logic [RATIO_W-1:0] exp_ratio;

   assign lin_f    = word[LIN_W-1:0];
   assign exp_f    = word[LIN_W +: EXP_W];
   assign lin_mode = word[CTL_W-1];

   assign lin_ratio = (RATIO_W'(lin_f) + RATIO_W'(1)) << 1;

   // one-hot power of two; exponent 0 is folded onto ratio 2
   for (genvar i = 0; i < RATIO_W; i++) begin : g_pow
      if (i == 0) begin : g_b0
         assign exp_ratio[i] = 1'b0;
      end else if (i == 1) begin : g_b1
         assign exp_ratio[i] = (exp_f == EXP_W'(0)) || (exp_f == EXP_W'(1));
      end else if (i < 2 ** EXP_W) begin : g_bn
         assign exp_ratio[i] = (exp_f == EXP_W'(i));
      end else begin : g_bz
         assign exp_ratio[i] = 1'b0;
      end
   end

   assign ratio = lin_mode ? lin_ratio : exp_ratio;
   assign half  = ratio[RATIO_W-1:1];
endmodule

// File: rtl/spidiv_counter.sv
module spidiv_counter #(
   parameter int HALF_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              restart,
   input  logic [HALF_W-1:0] reload_half,
   input  logic [HALF_W-1:0] run_half,
   output logic              tick
);
   logic [HALF_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (restart) begin
         cnt  <= reload_half - HALF_W'(1);
         tick <= 1'b0;
      end else if (en) begin
         if (cnt == '0) begin
            cnt  <= run_half - HALF_W'(1);
            tick <= 1'b1;
         end else begin
            cnt  <= cnt - HALF_W'(1);
            tick <= 1'b0;
         end
      end else begin
         tick <= 1'b0;
      end
   end

   assert_cnt_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < run_half);
   assert_gated_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !tick);
   assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !restart) |=> $stable(cnt));
   assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !tick);
   assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run_half != HALF_W'(1)) |=> !tick);
endmodule

// File: rtl/spidiv_sck_gen.sv
module spidiv_sck_gen
   import spidiv_pkg::*;
#(
   parameter int LIN_W   = 8,
   parameter int EXP_W   = 4,
   localparam int CTL_W   = LIN_W + EXP_W + 1,
   localparam int RATIO_W = imax(LIN_W + 2, 2 ** EXP_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               ctl_wr,
   input  logic [CTL_W-1:0]   ctl_word,
   input  logic               burst_start,
   output logic               tick,
   output logic [RATIO_W-1:0] ratio
);
   initial begin
      if (LIN_W < 1 || LIN_W > 16) $error("LIN_W out of range");
      if (EXP_W < 1 || EXP_W > 5)  $error("EXP_W out of range");
   end

   logic [CTL_W-1:0]   ctl_q;
   logic [RATIO_W-1:0] ratio_new;
   logic [RATIO_W-2:0] half_q, half_new, reload_half;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_wr) ctl_q <= ctl_word;
   end

   spidiv_decode #(.LIN_W(LIN_W), .EXP_W(EXP_W)) u_dec_cur (
      .word(ctl_q), .ratio(ratio), .half(half_q));

   spidiv_decode #(.LIN_W(LIN_W), .EXP_W(EXP_W)) u_dec_new (
      .word(ctl_word), .ratio(ratio_new), .half(half_new));

   assign reload_half = ctl_wr ? half_new : half_q;

   spidiv_counter #(.HALF_W(RATIO_W - 1)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(en),
      .restart(ctl_wr | burst_start),
      .reload_half(reload_half), .run_half(half_q), .tick(tick));

   assert_ratio_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio[0] == 1'b0) && (ratio >= RATIO_W'(2)));
   assert_pow2_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q[CTL_W-1] |-> $countones(ratio) == 1);
   assert_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> ratio == $past(ratio_new));
   assert_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> $stable(ratio));
endmodule

// File: tb/sim_spidiv_sck_gen.sv
module sim_spidiv_sck_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [12:0] ctl_word = '0;
   logic        burst_start = 1'b0;
   logic        tick;
   logic [15:0] ratio;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   spidiv_sck_gen u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .ctl_wr(ctl_wr),
      .ctl_word(ctl_word), .burst_start(burst_start),
      .tick(tick), .ratio(ratio));

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected below 150000", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [12:0] lin_w(input int n, input int e);
      return {1'b1, 4'(e), 8'(n)};
   endfunction
   function automatic logic [12:0] exp_w(input int e, input int n);
      return {1'b0, 4'(e), 8'(n)};
   endfunction

   // cycles from the current negedge until tick is seen
   task automatic until_tick(output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!tick);
   endtask

   task automatic write_word(input logic [12:0] w);
      @(negedge clk); ctl_word = w; ctl_wr = 1'b1;
      @(negedge clk); ctl_wr = 1'b0;
   endtask

   task automatic t_setting(input string req, input logic [12:0] w, input int exp_ratio);
      int n;
      write_word(w);
      chk({req, " ratio"}, ratio, exp_ratio);
      until_tick(n);
      chk({req, " first tick R6"}, n, exp_ratio / 2);
      until_tick(n);
      chk({req, " spacing R5"}, n, exp_ratio / 2);
   endtask

   task automatic t_reset;
      chk("R1 reset ratio", ratio, 2);
      chk("R1 reset tick", tick, 0);
   endtask

   task automatic t_pulse;
      int n;
      write_word(lin_w(3, 0));
      until_tick(n);
      @(negedge clk);
      chk("R8 single pulse", tick, 0);
   endtask

   task automatic t_burst;
      int n, hi;
      write_word(lin_w(9, 0));
      repeat (3) @(negedge clk);
      burst_start = 1'b1;
      @(negedge clk); burst_start = 1'b0;
      until_tick(n);
      chk("R7 burst restart", n, 10);
   endtask

   task automatic t_enable;
      int n, hi;
      en = 1'b0;
      write_word(lin_w(3, 0));
      hi = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (tick) hi++;
      end
      chk("R9 no tick while off", hi, 0);
      en = 1'b1;
      until_tick(n);
      chk("R9 resumes held count", n, 4);
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      en = 1'b1;
      @(negedge clk);
      t_setting("R2 N=0",   lin_w(0, 0),    2);
      t_setting("R2 N=4",   lin_w(4, 0),    10);
      t_setting("R2 N=255", lin_w(255, 0),  512);
      t_setting("R3 E=0",   exp_w(0, 0),    2);
      t_setting("R3 E=1",   exp_w(1, 0),    2);
      t_setting("R3 E=3",   exp_w(3, 0),    8);
      t_setting("R3 E=15",  exp_w(15, 0),   32768);
      t_setting("R10 lin ignores E", lin_w(5, 15), 12);
      t_setting("R10 exp ignores N", exp_w(2, 200), 4);
      t_pulse();
      t_burst();
      t_enable();
      chk("R4 ratio even", ratio % 2, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule